// File: doc/BRIEF.md
# Serial Flash Shift Engine

This block is the bit-level core of a single-lane serial flash host. It takes entries from a transmit FIFO. Each entry is a 32-bit value with a length code giving 1 to 4 valid bytes. The block shifts those bytes out on a serial data line while it toggles a generated serial clock. It samples the data-in line on the opposite clock edges and builds the received bits into a 32-bit word. When an entry finishes, that word is pushed into a receive FIFO.

The serial clock comes from the reference clock through a power-of-two divider. Clock polarity and clock phase can each be selected. The active-low chip select follows a control bit held by software. A global enable bit gates all activity. While the block is enabled and idle, it starts the next entry as soon as the transmit FIFO reports data. Software normally lowers the select bit, queues the command, address and data entries, waits for the matching receive pushes and then raises the select bit again.

Top module: `sflash_shift_engine`

## Requirements
- R1: With divider code d on `div_sel_i`, each serial clock level lasts 2^d reference cycles, so the serial clock is the reference divided by 2^(d+1). Code 0 gives divide-by-2 and code 7 gives divide-by-256. The code is sampled in the cycle an entry is popped.
- R2: When no entry is being shifted, `sclk_o` equals `cpol_i`. Every entry makes an even number of clock edges, so the clock always ends at its idle level.
- R3: With `cpha_i`=0 (sampled at pop), the first bit is on `sdo_o` before the first edge, data is captured on each leading edge and changed on each trailing edge. With `cpha_i`=1, data is changed on leading edges and captured on trailing edges.
- R4: `cs_no` is `cs_ctrl_i` delayed by one reference cycle. A 1 deasserts the select (high) and a 0 asserts it (low).
- R5: Length code `tx_len_i` = 0 means 4 bytes and codes 1, 2 and 3 mean that many bytes. An entry of N bytes takes exactly 8·N serial clock cycles, which is 16·N·2^d enabled reference cycles.
- R6: Transmit byte j is `tx_data_i[8j+7:8j]`. Byte 0 is sent first, and each byte is sent most-significant bit first.
- R7: In the received word, byte j of an N-byte entry sits at bits [8(4−N+j)+7 : 8(4−N+j)], so the received bytes are packed into the high-order end. Bits below the received bytes are zero.
- R8: Exactly one one-cycle `rx_push_o` pulse occurs per entry, in the cycle after that entry's final serial clock edge. `rx_data_o` carries the word in that cycle.
- R9: While `enable_i` is low, no entry is popped. An entry in progress freezes: the clock level, the edge count and the divider all hold, and they resume when the enable returns.
- R10: `tx_pop_o` is asserted combinationally in any cycle where the engine is idle, enabled and `tx_valid_i` is high. This can be the same cycle as the previous entry's push. The first edge of the new entry follows 2^d cycles after the pop.
- R11: After reset, `cs_no` is 1, `tx_pop_o` and `rx_push_o` are 0 and `sclk_o` equals `cpol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable |
| div_sel_i | input | 3 | Power-of-two divider code |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Capture edge select |
| cs_ctrl_i | input | 1 | Select control, 1 = deasserted |
| tx_valid_i | input | 1 | Transmit FIFO not empty |
| tx_data_i | input | 32 | Transmit FIFO head value |
| tx_len_i | input | 2 | Head length code (0 = 4 bytes) |
| tx_pop_o | output | 1 | Pop the transmit FIFO head |
| rx_push_o | output | 1 | Push a received word |
| rx_data_o | output | 32 | Received word |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The pop is combinational and is due in the same cycle in which idle, enable and valid coincide. The chip select is due one cycle after its control bit. The first serial edge comes 2^d cycles after the pop edge, and each further edge 2^d enabled cycles after the one before. The push arrives in the cycle after the 16·N-th edge. The bench model counts enabled cycles from each pop and derives every one of these instants from that count. It compares every output at the falling reference edge, half a cycle clear of the sampling edge. It checks `sdo_o` in each cycle just before a capture edge. `sdi_i` is looped back from `sdo_o`, either true or inverted, so the expected received word follows from the transmitted bytes.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } sfe_state_e;
endpackage

// File: rtl/sfe_clk_div.sv
module sfe_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam logic [CNT_W:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim;

  assign lim    = (ONE << exp_i) - ONE;
  assign tick_o = run_i && ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} <= lim)); // R1
endmodule

// File: rtl/sfe_tx_ser.sv
module sfe_tx_ser #(
  parameter int NBYTES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                preload_i,
  input  logic [8*NBYTES-1:0] data_i,
  input  logic                launch_i,
  output logic                sdo_o
);
  localparam int W = 8 * NBYTES;

  logic [W-1:0] swapped;
  logic [W-1:0] sr_q;

  // byte 0 goes to the top so the next bit is always the MSB
  for (genvar j = 0; j < NBYTES; j++) begin : g_swap
    assign swapped[8*(NBYTES-1-j) +: 8] = data_i[8*j +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      if (preload_i) begin
        sdo_o <= swapped[W-1];
        sr_q  <= swapped << 1;
      end else begin
        sr_q  <= swapped;
      end
    end else if (launch_i) begin
      sdo_o <= sr_q[W-1];
      sr_q  <= sr_q << 1;
    end
  end
endmodule

// File: rtl/sfe_rx_deser.sv
module sfe_rx_deser #(
  parameter int NBYTES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                capture_i,
  input  logic                sdi_i,
  output logic [8*NBYTES-1:0] word_o
);
  localparam int W = 8 * NBYTES;

  logic [2:0]   bit_q;
  logic [6:0]   byte_q;
  logic [W-1:0] word_q;
  logic [7:0]   byte_nxt;

  assign byte_nxt = {byte_q, sdi_i};
  // completed bytes enter at the top, older bytes move down
  assign word_o   = (capture_i && bit_q == 3'd7) ? {byte_nxt, word_q[W-1:8]} : word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
      word_q <= '0;
    end else if (clear_i) begin
      bit_q  <= '0;
      byte_q <= '0;
      word_q <= '0;
    end else if (capture_i) begin
      bit_q  <= bit_q + 3'd1;
      byte_q <= byte_nxt[6:0];
      word_q <= word_o;
    end
  end
endmodule

// File: rtl/sflash_shift_engine.sv
module sflash_shift_engine
  import sfe_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int DIV_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enable_i,
  input  logic [DIV_W-1:0]       div_sel_i,
  input  logic                   cpol_i,
  input  logic                   cpha_i,
  input  logic                   cs_ctrl_i,
  input  logic                   tx_valid_i,
  input  logic [8*NBYTES-1:0]    tx_data_i,
  input  logic [$clog2(NBYTES)-1:0] tx_len_i,
  output logic                   tx_pop_o,
  output logic                   rx_push_o,
  output logic [8*NBYTES-1:0]    rx_data_o,
  output logic                   sclk_o,
  output logic                   sdo_o,
  input  logic                   sdi_i,
  output logic                   cs_no
);
  localparam int DATA_W = 8 * NBYTES;
  localparam int LEN_W  = $clog2(NBYTES);
  localparam int NB_W   = LEN_W + 1;
  localparam int EDGE_W = NB_W + 4;

  sfe_state_e        state_q;
  logic [NB_W-1:0]   nb_q, nb_in;
  logic [DIV_W-1:0]  div_q;
  logic              cpha_q;
  logic              ph_q;
  logic [EDGE_W-1:0] edge_q, edge_end;
  logic              tick, run, leading, capture, launch, last;
  logic [DATA_W-1:0] rx_word;

  assign nb_in    = (tx_len_i == '0) ? NB_W'(NBYTES) : {1'b0, tx_len_i};
  assign edge_end = {nb_q, 4'b0000} - EDGE_W'(1);
  assign tx_pop_o = (state_q == ST_IDLE) && enable_i && tx_valid_i;
  assign run      = (state_q == ST_SHIFT) && enable_i;
  assign leading  = ~edge_q[0];
  assign last     = (edge_q == edge_end);
  assign capture  = tick && (leading ^ cpha_q);
  assign launch   = tick && (leading == cpha_q) && !last;
  assign sclk_o   = ph_q ^ cpol_i;

  sfe_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tx_pop_o),
    .run_i   (run),
    .exp_i   (div_q),
    .tick_o  (tick)
  );

  sfe_tx_ser #(.NBYTES(NBYTES)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tx_pop_o),
    .preload_i (~cpha_i),
    .data_i    (tx_data_i),
    .launch_i  (launch),
    .sdo_o     (sdo_o)
  );

  sfe_rx_deser #(.NBYTES(NBYTES)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (tx_pop_o),
    .capture_i (capture),
    .sdi_i     (sdi_i),
    .word_o    (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nb_q      <= '0;
      div_q     <= '0;
      cpha_q    <= 1'b0;
      ph_q      <= 1'b0;
      edge_q    <= '0;
      rx_push_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      rx_push_o <= 1'b0;
      if (tx_pop_o) begin
        state_q <= ST_SHIFT;
        nb_q    <= nb_in;
        div_q   <= div_sel_i;
        cpha_q  <= cpha_i;
        edge_q  <= '0;
      end else if (tick) begin
        ph_q   <= ~ph_q;
        edge_q <= edge_q + 1'b1;
        if (last) begin
          state_q   <= ST_IDLE;
          rx_push_o <= 1'b1;
          rx_data_o <= rx_word;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_no <= 1'b1;
    else         cs_no <= cs_ctrl_i;
  end

  logic cs_hist_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_hist_q <= 1'b0;
    else         cs_hist_q <= 1'b1;
  end

  AST_CS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hist_q |-> (cs_no == $past(cs_ctrl_i))); // R4
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (sclk_o == cpol_i)); // R2
  AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> (edge_q <= edge_end)); // R5
  AST_PUSH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> (state_q == ST_IDLE && !ph_q)); // R8
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !enable_i) |=> ($stable(edge_q) && $stable(ph_q))); // R9
  AST_NO_BACK2BACK_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> !tx_pop_o); // R10
endmodule

// File: tb/sflash_shift_engine_tb.sv
module sflash_shift_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  div = '0;
  logic        cpol = 1'b0, cpha = 1'b0, cs_ctrl = 1'b1, inv = 1'b0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic [1:0]  tx_len = '0;
  logic        tx_pop, rx_push, sclk, sdo, sdi, cs_n;
  logic [31:0] rx_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [33:0] txq[$];

  // model state
  bit          m_busy = 0, m_ph = 0, m_push = 0, m_cs = 1, m_cpha = 0, m_inv = 0;
  int          m_k = 0, m_H = 1, m_N = 1;
  logic [31:0] m_data = '0, m_rxd = '0;

  always #2 clk = ~clk;
  assign sdi = sdo ^ inv;

  sflash_shift_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .div_sel_i(div),
    .cpol_i(cpol), .cpha_i(cpha), .cs_ctrl_i(cs_ctrl), .tx_valid_i(tx_valid),
    .tx_data_i(tx_data), .tx_len_i(tx_len), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .sclk_o(sclk), .sdo_o(sdo),
    .sdi_i(sdi), .cs_no(cs_n)
  );

  function automatic logic txbit(input logic [31:0] d, input int b);
    return d[8*(b/8) + 7 - (b%8)];
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] d, input int n, input bit iv);
    logic [31:0] w = '0;
    for (int j = 0; j < n; j++) w = {d[8*j +: 8] ^ {8{iv}}, w[31:8]};
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      finish_run();
    end
  end

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ph = 0; m_push = 0; m_cs = 1; m_k = 0;
    end else begin
      m_push = 0;
      m_cs   = cs_ctrl;
      if (!m_busy) begin
        if (en && tx_valid) begin
          logic [33:0] ent;
          ent    = txq.pop_front();
          m_data = ent[31:0];
          m_N    = (ent[33:32] == 2'd0) ? 4 : int'(ent[33:32]);
          m_H    = 1 << div;
          m_cpha = cpha;
          m_inv  = inv;
          m_k    = 0;
          m_busy = 1;
        end
      end else if (en) begin
        m_k++;
        if (m_k % m_H == 0) begin
          m_ph = ~m_ph;
          if (m_k == 16 * m_N * m_H) begin
            m_busy = 0;
            m_push = 1;
            m_rxd  = exp_rx(m_data, m_N, m_inv);
          end
        end
      end
    end
  end

  // FIFO head drive and comparison away from the active edge
  always @(negedge clk) begin
    if (txq.size() != 0) begin
      tx_valid = 1'b1;
      {tx_len, tx_data} = txq[0];
    end else begin
      tx_valid = 1'b0;
    end
    #1;
    if (rst_n) begin
      chk(en ? "R10 pop" : "R9 pop", 32'(tx_pop), 32'(!m_busy && en && tx_valid));
      chk(m_busy ? "R1 R9 sclk" : "R2 sclk idle", 32'(sclk), 32'(m_ph ^ cpol));
      chk("R5 R8 push", 32'(rx_push), 32'(m_push));
      if (m_push) chk("R7 rx word", rx_data, m_rxd);
      chk("R4 cs", 32'(cs_n), 32'(m_cs));
      if (m_busy && en && ((m_k + 1) % m_H == 0)) begin
        int e;
        e = (m_k + 1) / m_H - 1;
        if (((e % 2) == 0) != m_cpha)
          chk("R3 R6 sdo", 32'(sdo), 32'(txbit(m_data, e / 2)));
      end
    end
  end

  task automatic push(input logic [1:0] l, input logic [31:0] d);
    txq.push_back({l, d});
  endtask

  task automatic drain();
    do @(negedge clk); while (txq.size() != 0 || m_busy || tx_valid);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] d, input bit pol, input bit pha, input bit iv);
    @(negedge clk);
    div = d; cpol = pol; cpha = pha; inv = iv;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11 cs reset", 32'(cs_n), 32'd1);
    chk("R11 pop reset", 32'(tx_pop), 32'd0);
    chk("R11 push reset", 32'(rx_push), 32'd0);
    chk("R11 sclk reset", 32'(sclk), 32'(cpol));
    @(negedge clk);
    rst_n = 1'b1;

    // divide-by-2, mode 0, all four length codes
    setup(3'd0, 0, 0, 0);
    cs_ctrl = 1'b0; en = 1'b1;
    push(2'd0, 32'hA5C3_1E87);
    push(2'd1, 32'hFFFF_FF5A);
    push(2'd2, 32'h0000_81E4);
    push(2'd3, 32'h00C0_FFEE);
    drain();

    // divide-by-4, mode 3, inverted loopback
    setup(3'd1, 1, 1, 1);
    push(2'd3, 32'h0012_3456);
    push(2'd0, 32'h8001_7FFE);
    push(2'd1, 32'h0000_0081);
    push(2'd2, 32'hFFFF_3CC3);
    drain();

    // divide-by-256 boundary, single byte
    setup(3'd7, 0, 1, 0);
    push(2'd1, 32'h0000_00C6);
    drain();

    // enable dropped mid-entry
    setup(3'd2, 1, 0, 1);
    push(2'd0, 32'h1234_5678);
    push(2'd2, 32'h0000_BEEF);
    repeat (37) @(negedge clk);
    en = 1'b0;
    repeat (20) @(negedge clk);
    en = 1'b1;
    repeat (300) @(negedge clk);
    en = 1'b0;
    repeat (9) @(negedge clk);
    en = 1'b1;
    drain();

    // disabled with data queued: no pop
    setup(3'd0, 0, 0, 0);
    en = 1'b0;
    push(2'd2, 32'h0000_6699);
    repeat (10) @(negedge clk);
    en = 1'b1;
    drain();
    cs_ctrl = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule